// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, in a single combinational pass, whether one memory access may go ahead under a table of protection entries covering a 32-bit physical address space. Every entry carries an 8-bit configuration byte and a 32-bit address register. Each entry is decoded into an inclusive byte range: not at all when it is switched off, as a span bounded by the previous entry (top-of-range), as a naturally aligned 4-byte word, or as a naturally aligned power-of-two block. The access is then compared with every decoded range, and the lowest-numbered entry that it touches decides the outcome.

The privilege used for the check is the effective one. A load or store issued in machine mode while the modify-privilege flag is set takes its privilege from the previous-privilege field. Instruction fetches always use the current mode. Machine mode is bound only by locked entries. Supervisor and user accesses that hit no entry are refused. The block is meant to sit beside a load/store unit or a fetch unit and gate the access in the same cycle in which the address is presented.

Top module: `pmpc_checker`

## Requirements
- R1: The configuration byte of each entry holds read permission in bit 0, write in bit 1, execute in bit 2, the address mode in bits 4:3 (0 off, 1 top-of-range, 2 4-byte, 3 power-of-two) and the lock in bit 7. The access kind is encoded 0 read, 1 write, 2 fetch. Kind 3 is granted by no permission bit. Privilege is encoded 0 user, 1 supervisor, 3 machine.
- R2: In the 4-byte mode, an entry covers the address register bits 29:0 shifted left by two, through that value plus 3.
- R3: In the power-of-two mode, an address register with t trailing ones covers 2^(t+3) bytes, aligned to that size. Register 0x20003fff covers 0x80000000 to 0x8001ffff.
- R4: A power-of-two register of 0x1fffffff, or one whose bits 29:0 are all ones, covers the whole range 0x00000000 to 0xffffffff. It never yields an empty or wrapped range.
- R5: A top-of-range entry covers from the previous entry's shifted register (0 for entry 0) up to, but not including, its own shifted register. When that start is not below that end, the entry matches nothing.
- R6: An entry whose mode is off never matches, whatever its register and permission bits hold.
- R7: An entry matches fully only when both the first byte (address) and the last byte (address + length - 1) of the access lie inside its inclusive range. The length is 1 to 8 bytes, and 0 is taken as 1. A last byte beyond 0xffffffff lies outside every range.
- R8: When the deciding entry holds only some of the bytes of the access, the access is refused at every privilege.
- R9: When no entry touches the access, it is allowed in machine mode and refused in supervisor and user mode. This includes the case where every entry is off.
- R10: In machine mode, a fully matching unlocked entry allows the access. A fully matching locked entry grants it only when the permission bit for its kind is set.
- R11: For reads and writes, a current privilege of machine with the modify-privilege input set takes its effective privilege from the previous-privilege input. Fetches, and any other current privilege, use the current privilege.
- R12: Among all entries that touch the access, the lowest-numbered one decides. For supervisor and user, the decision is its permission bit for the access kind.
- R13: `hit` is high when some entry touches the access, and `hit_idx` then gives the number of the deciding entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | 32 | Address of the first byte of the access |
| acc_len | input | 4 | Access length in bytes (1 to 8, 0 taken as 1) |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mprv_en | input | 1 | Modify-privilege flag for loads and stores |
| mpp_priv | input | 2 | Previous-privilege field used when the flag applies |
| ent_cfg | input | 8*NUM_ENTRIES | Configuration bytes; entry i in bits 8i+7:8i |
| ent_addr | input | 32*NUM_ENTRIES | Address registers; entry i in bits 32i+31:32i |
| allow | output | 1 | Access permitted |
| hit | output | 1 | Some entry touches the access |
| hit_idx | output | IDX_W | Number of the deciding entry, valid when hit is high |

## Verification
Every output depends only on the present inputs, so each result is due in the same cycle as its stimulus, with no register on the path. The bench changes the inputs 1 ns after a rising edge and reads `allow`, `hit` and `hit_idx` at the following falling edge, when the combinational paths have long settled. It then compares them with a bench model that decodes entries using 64-bit arithmetic and explicit trailing-one counting. The index is compared only when a hit is expected.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // bit 7 lock, 6:5 unused, 4:3 mode, 2 x, 1 w, 0 r
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     mode;
        logic       px;
        logic       pw;
        logic       pr;
    } cfg_t;

    // inclusive byte range
    typedef struct packed {
        logic        valid;
        logic [31:0] lo;
        logic [31:0] hi;
    } range_t;

endpackage

// File: rtl/pmpc_region_decode.sv
module pmpc_region_decode
    import pmpc_pkg::*;
(
    input  amode_e      mode,
    input  logic [31:0] own_reg,
    input  logic [31:0] prev_reg,
    output range_t      rng
);
    logic [31:0] own_sh;
    logic [31:0] prev_sh;
    logic [31:0] napot_x;
    logic [31:0] napot_mask;

    assign own_sh     = {own_reg[29:0], 2'b00};
    assign prev_sh    = {prev_reg[29:0], 2'b00};
    // trailing ones plus the first zero above them form the size mask;
    // an all-ones value wraps to zero and the mask becomes all ones
    assign napot_x    = own_sh | 32'd3;
    assign napot_mask = napot_x ^ (napot_x + 32'd1);

    always_comb begin
        rng = '0;
        unique case (mode)
            AM_OFF: begin
                rng.valid = 1'b0;
            end
            AM_TOR: begin
                if (prev_sh < own_sh) begin
                    rng.valid = 1'b1;
                    rng.lo    = prev_sh;
                    rng.hi    = own_sh - 32'd1;
                end
            end
            AM_NA4: begin
                rng.valid = 1'b1;
                rng.lo    = own_sh;
                rng.hi    = own_sh | 32'd3;
            end
            AM_NAPOT: begin
                rng.valid = 1'b1;
                rng.lo    = napot_x & ~napot_mask;
                rng.hi    = napot_x | napot_mask;
            end
            default: rng = '0;
        endcase
    end
endmodule

// File: rtl/pmpc_entry_match.sv
module pmpc_entry_match
    import pmpc_pkg::*;
(
    input  range_t      rng,
    input  logic [31:0] first_b,
    input  logic [32:0] last_b,
    output logic        full,
    output logic        touch
);
    logic first_in;
    logic last_in;
    logic span;

    always_comb begin
        first_in = rng.valid && (first_b >= rng.lo) && (first_b <= rng.hi);
        last_in  = rng.valid && !last_b[32]
                   && (last_b[31:0] >= rng.lo) && (last_b[31:0] <= rng.hi);
        span     = rng.valid && (first_b < rng.lo)
                   && (last_b[32] || (last_b[31:0] > rng.hi));
        full     = first_in && last_in;
        touch    = first_in || last_in || span;
    end
endmodule

// File: rtl/pmpc_first_hit.sv
module pmpc_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker
    import pmpc_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [31:0]               acc_addr,
    input  logic [3:0]                acc_len,
    input  logic [1:0]                acc_kind,
    input  logic [1:0]                cur_priv,
    input  logic                      mprv_en,
    input  logic [1:0]                mpp_priv,
    input  logic [NUM_ENTRIES*8-1:0]  ent_cfg,
    input  logic [NUM_ENTRIES*32-1:0] ent_addr,
    output logic                      allow,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    localparam int CFG_W  = 8;
    localparam int ADDR_W = 32;

    cfg_t                   cfg_arr  [NUM_ENTRIES];
    range_t                 rng_arr  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] full_vec;
    logic [NUM_ENTRIES-1:0] touch_vec;
    logic [3:0]             len_m1;
    logic [32:0]            last_b;
    logic [1:0]             eff_priv;
    logic                   eff_m;
    cfg_t                   sel_cfg;
    logic                   sel_full;
    logic                   perm_ok;

    assign len_m1 = (acc_len == 4'd0) ? 4'd0 : (acc_len - 4'd1);
    assign last_b = {1'b0, acc_addr} + {29'd0, len_m1};

    assign eff_priv = (acc_kind != ACC_EXEC && mprv_en && cur_priv == PRIV_M)
                      ? mpp_priv : cur_priv;
    assign eff_m    = (eff_priv == PRIV_M);

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
        logic [31:0] prev_reg;
        assign cfg_arr[gi] = cfg_t'(ent_cfg[gi*CFG_W +: CFG_W]);
        if (gi == 0) begin : g_head
            assign prev_reg = '0;
        end else begin : g_tail
            assign prev_reg = ent_addr[(gi-1)*ADDR_W +: ADDR_W];
        end

        pmpc_region_decode u_dec (
            .mode     (cfg_arr[gi].mode),
            .own_reg  (ent_addr[gi*ADDR_W +: ADDR_W]),
            .prev_reg (prev_reg),
            .rng      (rng_arr[gi])
        );

        pmpc_entry_match u_match (
            .rng     (rng_arr[gi]),
            .first_b (acc_addr),
            .last_b  (last_b),
            .full    (full_vec[gi]),
            .touch   (touch_vec[gi])
        );
    end

    pmpc_first_hit #(
        .N     (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) u_pick (
        .req   (touch_vec),
        .found (hit),
        .idx   (hit_idx)
    );

    assign sel_cfg  = cfg_arr[hit_idx];
    assign sel_full = full_vec[hit_idx];

    always_comb begin
        unique case (acc_e'(acc_kind))
            ACC_READ:  perm_ok = sel_cfg.pr;
            ACC_WRITE: perm_ok = sel_cfg.pw;
            ACC_EXEC:  perm_ok = sel_cfg.px;
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (!hit) begin
            allow = eff_m;
        end else if (!sel_full) begin
            allow = 1'b0;
        end else if (eff_m && !sel_cfg.lock) begin
            allow = 1'b1;
        end else begin
            allow = perm_ok;
        end
    end
endmodule

// File: rtl/pmpc_checker_sva.sv
module pmpc_checker_sva
    import pmpc_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input logic [31:0]               acc_addr,
    input logic [3:0]                acc_len,
    input logic [1:0]                acc_kind,
    input logic [1:0]                cur_priv,
    input logic                      mprv_en,
    input logic [1:0]                mpp_priv,
    input logic [NUM_ENTRIES*8-1:0]  ent_cfg,
    input logic [NUM_ENTRIES*32-1:0] ent_addr,
    input logic                      allow,
    input logic                      hit,
    input logic [IDX_W-1:0]          hit_idx
);
    logic [1:0] chk_priv;
    cfg_t       chk_cfg;
    logic       chk_perm;

    always_comb begin
        chk_priv = cur_priv;
        if (acc_kind != 2'd2 && mprv_en && cur_priv == 2'd3) chk_priv = mpp_priv;
        chk_cfg  = cfg_t'(ent_cfg[32'(hit_idx)*8 +: 8]);
        chk_perm = (acc_kind == 2'd0) ? chk_cfg.pr :
                   (acc_kind == 2'd1) ? chk_cfg.pw :
                   (acc_kind == 2'd2) ? chk_cfg.px : 1'b0;

        // R9: no entry touched refuses supervisor and user
        if (!hit && chk_priv != 2'd3)
            a_r9_nomatch_su: assert (!allow) else $error("R9 lower-privilege miss allowed");
        // R9: no entry touched lets machine mode through
        if (!hit && chk_priv == 2'd3)
            a_r9_nomatch_m: assert (allow) else $error("R9 machine miss refused");
        // R6: an off entry never decides
        if (hit)
            a_r6_off_never_hit: assert (chk_cfg.mode != AM_OFF) else $error("R6 off entry hit");
        // R10 / R12: an allowed access under a binding entry has its permission bit
        if (hit && allow && (chk_priv != 2'd3 || chk_cfg.lock))
            a_r10_locked_perm: assert (chk_perm) else $error("R10 granted without permission");
        // R11: fetch in machine mode ignores the modify-privilege flag
        if (!hit && acc_kind == 2'd2 && cur_priv == 2'd3)
            a_r11_fetch_cur_priv: assert (allow) else $error("R11 fetch used previous privilege");
        // R13: the index names an existing entry
        if (hit)
            a_r13_idx_range: assert (32'(hit_idx) < NUM_ENTRIES) else $error("R13 index out of range");
    end
endmodule

bind pmpc_checker pmpc_checker_sva #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
) u_sva (
    .acc_addr (acc_addr),
    .acc_len  (acc_len),
    .acc_kind (acc_kind),
    .cur_priv (cur_priv),
    .mprv_en  (mprv_en),
    .mpp_priv (mpp_priv),
    .ent_cfg  (ent_cfg),
    .ent_addr (ent_addr),
    .allow    (allow),
    .hit      (hit),
    .hit_idx  (hit_idx)
);

// File: tb/tb_pmpc_checker.sv
module tb_pmpc_checker;
    localparam int N     = 16;
    localparam int IDX_W = 4;
    localparam longint unsigned TOP = 64'h1_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [31:0]      acc_addr = '0;
    logic [3:0]       acc_len  = 4'd1;
    logic [1:0]       acc_kind = '0;
    logic [1:0]       cur_priv = '0;
    logic             mprv_en  = 1'b0;
    logic [1:0]       mpp_priv = '0;
    logic [7:0]       cfg_a [N];
    logic [31:0]      adr_a [N];
    logic [N*8-1:0]   cfg_bus;
    logic [N*32-1:0]  adr_bus;
    logic             allow;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_bus[i*8 +: 8]   = cfg_a[i];
            adr_bus[i*32 +: 32] = adr_a[i];
        end
    end

    pmpc_checker #(.NUM_ENTRIES(N)) dut (
        .acc_addr (acc_addr),
        .acc_len  (acc_len),
        .acc_kind (acc_kind),
        .cur_priv (cur_priv),
        .mprv_en  (mprv_en),
        .mpp_priv (mpp_priv),
        .ent_cfg  (cfg_bus),
        .ent_addr (adr_bus),
        .allow    (allow),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    // bench model: 64-bit ranges with exclusive end
    function automatic void ref_range(input int i, output bit v,
                                      output longint unsigned lo, output longint unsigned hx);
        longint unsigned sh, psh, sz;
        int t;
        sh  = longint'(adr_a[i][29:0]) << 2;
        psh = (i == 0) ? 64'd0 : (longint'(adr_a[i-1][29:0]) << 2);
        v = 1'b0; lo = 0; hx = 0;
        case (cfg_a[i][4:3])
            2'd1: if (psh < sh) begin v = 1'b1; lo = psh; hx = sh; end
            2'd2: begin v = 1'b1; lo = sh; hx = sh + 4; end
            2'd3: begin
                t = 0;
                while (t < 30 && adr_a[i][t]) t++;
                sz = 64'd1 << (t + 3);
                v = 1'b1; lo = sh & ~(sz - 1); hx = lo + sz;
            end
            default: v = 1'b0;
        endcase
        if (hx > TOP) hx = TOP;
    endfunction

    function automatic void ref_eval(output bit e_allow, output bit e_hit, output int e_idx);
        longint unsigned f, lx, lo, hx;
        bit v, full, m;
        logic [1:0] p;
        bit perm;
        f  = longint'(acc_addr);
        lx = f + ((acc_len == 0) ? 64'd1 : longint'(acc_len));
        p  = (acc_kind != 2 && mprv_en && cur_priv == 3) ? mpp_priv : cur_priv;
        m  = (p == 2'd3);
        e_hit = 1'b0; e_idx = 0; full = 1'b0;
        for (int i = 0; i < N; i++) begin
            ref_range(i, v, lo, hx);
            if (!e_hit && v && f < hx && lx > lo) begin
                e_hit = 1'b1; e_idx = i;
                full  = (f >= lo) && (lx <= hx) && (lx <= TOP);
            end
        end
        if (!e_hit) e_allow = m;
        else if (!full) e_allow = 1'b0;
        else if (m && !cfg_a[e_idx][7]) e_allow = 1'b1;
        else begin
            perm = (acc_kind == 0) ? cfg_a[e_idx][0] :
                   (acc_kind == 1) ? cfg_a[e_idx][1] :
                   (acc_kind == 2) ? cfg_a[e_idx][2] : 1'b0;
            e_allow = perm;
        end
    endfunction

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin cfg_a[i] = 8'h00; adr_a[i] = 32'h0; end
    endtask

    task automatic check_out(input string req, input bit ea, input bit eh, input int ei);
        n_vec++;
        if (allow !== ea || hit !== eh || (eh && int'(hit_idx) != ei)) begin
            n_fail++;
            $display("FAIL %s addr=%h len=%0d kind=%0d: got allow=%0b hit=%0b idx=%0d, expected allow=%0b hit=%0b idx=%0d",
                     req, acc_addr, acc_len, acc_kind, allow, hit, hit_idx, ea, eh, ei);
        end
    endtask

    // drive 1 ns after a rising edge, compare at the falling edge
    task automatic apply(input logic [31:0] a, input logic [3:0] l, input logic [1:0] k,
                         input logic [1:0] cp, input logic mp, input logic [1:0] pp);
        @(posedge clk);
        #1;
        acc_addr = a; acc_len = l; acc_kind = k; cur_priv = cp; mprv_en = mp; mpp_priv = pp;
        @(negedge clk);
    endtask

    task automatic dir(input string req, input logic [31:0] a, input logic [3:0] l,
                       input logic [1:0] k, input logic [1:0] cp, input logic mp,
                       input logic [1:0] pp, input bit ea, input bit eh, input int ei);
        bit ra, rh; int ri;
        apply(a, l, k, cp, mp, pp);
        ref_eval(ra, rh, ri);
        if (ra != ea || rh != eh) $display("note: bench model disagrees with directed value for %s", req);
        check_out(req, ea, eh, ei);
    endtask

    task automatic rand_entries();
        int k;
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            cfg_a[i] = {($urandom % 8 == 0), 2'b00, 2'($urandom), 3'($urandom)};
            r = 32'h2000_0000 | ($urandom & 32'h3ff);
            if (cfg_a[i][4:3] == 2'd3) begin
                k = int'($urandom % 10);
                r = (r | ((32'd1 << k) - 1)) & ~(32'd1 << k);
            end
            if ($urandom % 32 == 0) r = 32'h1fff_ffff;
            adr_a[i] = r;
        end
    endtask

    function automatic logic [1:0] rand_priv();
        int s = int'($urandom % 3);
        return (s == 2) ? 2'd3 : 2'(s);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        bit ra, rh; int ri;
        logic [3:0] lens [4];
        lens[0] = 4'd1; lens[1] = 4'd2; lens[2] = 4'd4; lens[3] = 4'd8;
        void'($urandom(32'd1234));
        clear_all();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R9: after reset all entries off
        dir("R9 idle user", 32'h0, 4'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0);
        dir("R9 idle machine", 32'h0, 4'd1, 2'd0, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 0);
        dir("R9 idle supervisor", 32'h1234, 4'd4, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 0);

        // R3: 128 KB block at 0x80000000, read only
        clear_all(); cfg_a[0] = 8'h19; adr_a[0] = 32'h2000_3fff;
        dir("R3 R7 last byte", 32'h8001_ffff, 4'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R3 above block", 32'h8002_0000, 4'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0);
        dir("R3 below block", 32'h7fff_fffc, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0);
        dir("R1 write needs bit1", 32'h8000_0000, 4'd4, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        dir("R1 fetch needs bit2", 32'h8000_0000, 4'd4, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 0);

        // R4: whole space
        clear_all(); cfg_a[0] = 8'h1f; adr_a[0] = 32'h1fff_ffff;
        dir("R4 top word", 32'hffff_fffc, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R4 bottom", 32'h0, 4'd8, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R7 wrap past top", 32'hffff_fffc, 4'd8, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        dir("R1 kind 3 refused", 32'h100, 4'd4, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0);

        // R2: 4-byte word at 0x80001000
        clear_all(); cfg_a[0] = 8'h11; adr_a[0] = 32'h2000_0400;
        dir("R2 word", 32'h8000_1000, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R2 last byte", 32'h8000_1003, 4'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R2 next byte", 32'h8000_1004, 4'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0);
        dir("R8 partial tail", 32'h8000_1002, 4'd4, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        dir("R8 straddle both", 32'h8000_0ffe, 4'd8, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        dir("R7 len 0 as 1", 32'h8000_1003, 4'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);

        // R5: inverted top-of-range is empty
        clear_all();
        adr_a[0] = 32'h0000_40ff;
        cfg_a[1] = 8'h08; adr_a[1] = 32'h0000_32ff;
        cfg_a[2] = 8'h1f; adr_a[2] = 32'h1fff_ffff;
        dir("R5 empty range", 32'h0000_cc00, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2);
        adr_a[1] = 32'h0000_50ff;
        dir("R5 valid range", 32'h0001_0400, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1);
        dir("R5 end exclusive", 32'h0001_43fc, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2);
        cfg_a[0] = 8'h09; adr_a[0] = 32'h0000_0100;
        dir("R5 entry0 from zero", 32'h0000_03fc, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 0);

        // R6: off entry with full permissions
        clear_all(); cfg_a[0] = 8'h07; adr_a[0] = 32'h1fff_ffff;
        dir("R6 off ignored", 32'h0000_1000, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0);

        // R10: machine mode and lock
        clear_all(); cfg_a[0] = 8'h18; adr_a[0] = 32'h1fff_ffff;
        dir("R10 unlocked", 32'h4000_0000, 4'd4, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        cfg_a[0] = 8'h98;
        dir("R10 locked none", 32'h4000_0000, 4'd4, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        cfg_a[0] = 8'h9a;
        dir("R10 locked write", 32'h4000_0000, 4'd4, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 0);
        dir("R10 locked read", 32'h4000_0000, 4'd4, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 0);

        // R11: effective privilege
        clear_all();
        dir("R11 mprv to user", 32'h100, 4'd4, 2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 0);
        dir("R11 mprv to super", 32'h100, 4'd4, 2'd1, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 0);
        dir("R11 mprv to machine", 32'h100, 4'd4, 2'd1, 2'd3, 1'b1, 2'd3, 1'b1, 1'b0, 0);
        dir("R11 fetch ignores", 32'h100, 4'd4, 2'd2, 2'd3, 1'b1, 2'd0, 1'b1, 1'b0, 0);
        dir("R11 user ignores", 32'h100, 4'd4, 2'd0, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 0);

        // R12 / R13: lowest index wins
        clear_all();
        cfg_a[0] = 8'h10; adr_a[0] = 32'h2000_0400;
        cfg_a[1] = 8'h1f; adr_a[1] = 32'h1fff_ffff;
        dir("R12 lower wins", 32'h8000_1000, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0);
        dir("R13 second entry", 32'h8000_1004, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1);

        // random vectors against the bench model (R1..R13)
        for (int t = 0; t < 4000; t++) begin
            if (t % 8 == 0) rand_entries();
            apply(32'h7fff_fc00 + ($urandom & 32'h1fff), lens[$urandom % 4],
                  2'($urandom % 3), rand_priv(), 1'($urandom), rand_priv());
            ref_eval(ra, rh, ri);
            check_out("R12 random", ra, rh, ri);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule